// File: doc/BRIEF.md
# FIFO Link Port for a Processor Pipeline

This block sits between a processor's execute stage and a pair of one-way FIFO channels. One channel leaves the processor through an outgoing FIFO. The other arrives through an incoming FIFO. Every word on either channel carries a 32-bit payload and one tag bit. The tag bit marks the word as a control word (1) or a plain data word (0). The pipeline issues put and get requests. Each request has two qualifiers: blocking or non-blocking, and data or control. That gives eight variants in total.

A blocking request holds the pipeline through the `stall` output until the FIFO is ready. A non-blocking request always finishes at once. If it cannot transfer, it does nothing and raises a failure flag. A get also compares the tag of the word it receives with the flavour it asked for. On a mismatch it still completes, and it raises a control-error flag.

The controller is a three-state machine:

- `ST_IDLE` accepts requests and finishes every transfer that can go at once.
- `ST_WAIT_PUT` is entered from idle by a blocking put that meets a full FIFO. It returns to idle in the first cycle the FIFO has space.
- `ST_WAIT_GET` is entered from idle by a blocking get that meets an empty FIFO. It returns to idle in the first cycle a word exists.

All other cases stay in `ST_IDLE`.

Top module: `fifo_link_port`

## Requirements
- R1: After reset, `stall`, `done`, `ofifo_wr` and `ififo_rd` are 0, and `st_fail`, `st_ctrl_err` and `rdata` are 0.
- R2: A put issued in idle while `ofifo_full` is 0 raises `ofifo_wr` and `done` in that same cycle, for one cycle. `ofifo_data` equals `req_wdata` and `ofifo_ctrl` equals `req_ctrl` (1 = control word). `stall` stays 0.
- R3: A blocking put (`req_nonblk`=0) that meets `ofifo_full`=1 raises `stall` and does not write while full stays 1. In the first cycle full is 0, it writes once, raises `done` and drops `stall`.
- R4: A non-blocking put (`req_nonblk`=1) that meets a full FIFO raises `done` with no write, and `st_fail` reads 1 after that edge. Any successful put or get clears `st_fail` to 0 at its completion edge.
- R5: A get that finds `ififo_exists`=1 raises `ififo_rd` and `done` for one cycle. `rdata` holds `ififo_data` after that edge.
- R6: A blocking get that meets `ififo_exists`=0 raises `stall` and does not read until exists is 1. It then reads once and raises `done`.
- R7: A non-blocking get that meets an empty FIFO raises `done` with no read. After that edge, `st_fail` is 1, and `rdata` and `st_ctrl_err` are 0.
- R8: On a successful get, `st_ctrl_err` becomes 1 when `ififo_ctrl` differs from `req_ctrl`, and 0 when they match. Puts leave `st_ctrl_err` unchanged.
- R9: While a blocking request is stalled, changes on the request inputs are ignored. The word written is the one presented when the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until done |
| req_put | input | 1 | 1 = put, 0 = get |
| req_nonblk | input | 1 | 1 = non-blocking |
| req_ctrl | input | 1 | 1 = control flavour |
| req_wdata | input | 32 | Word to put |
| stall | output | 1 | Hold the pipeline |
| done | output | 1 | Request completes this cycle |
| rdata | output | 32 | Last word got |
| st_fail | output | 1 | Last non-blocking transfer failed |
| st_ctrl_err | output | 1 | Last get saw a tag mismatch |
| ofifo_wr | output | 1 | Write strobe to outgoing FIFO |
| ofifo_data | output | 32 | Outgoing word |
| ofifo_ctrl | output | 1 | Outgoing tag bit |
| ofifo_full | input | 1 | Outgoing FIFO full |
| ififo_rd | output | 1 | Read acknowledge to incoming FIFO |
| ififo_data | input | 32 | Incoming word |
| ififo_ctrl | input | 1 | Incoming tag bit |
| ififo_exists | input | 1 | Incoming FIFO not empty |

## Verification
The assertions assume that the FIFOs keep their full and exists flags truthful. They also assume that the pipeline holds `req_valid` high until `done`, and that it issues nothing new in the cycle after completion without first dropping `req_valid`. The stimulus changes every input on the falling edge only. It drops `req_valid` one cycle after each completion. It drives the FIFO flags directly and never reads from an empty FIFO or writes to a full one.

// File: rtl/fifo_link_pkg.sv
package fifo_link_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_PUT = 2'd1,
        ST_WAIT_GET = 2'd2
    } link_state_t;
endpackage

// File: rtl/fifo_link_fsm.sv
module fifo_link_fsm
    import fifo_link_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_put,
    input  logic              req_nonblk,
    input  logic              req_ctrl,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ofifo_full,
    input  logic              ififo_exists,
    output logic              stall,
    output logic              done,
    output logic              wr_pulse,
    output logic              rd_pulse,
    output logic              fail_ev,
    output logic              get_op,
    output logic              act_ctrl,
    output logic [DATA_W-1:0] act_data
);
    link_state_t state_q, state_d;
    logic              lat_ctrl;
    logic [DATA_W-1:0] lat_data;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request latch, loaded only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_ctrl <= 1'b0;
            lat_data <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            lat_ctrl <= req_ctrl;
            lat_data <= req_wdata;
        end
    end

    assign act_ctrl = (state_q == ST_IDLE) ? req_ctrl  : lat_ctrl;
    assign act_data = (state_q == ST_IDLE) ? req_wdata : lat_data;

    // outputs and next state
    always_comb begin
        state_d  = state_q;
        stall    = 1'b0;
        done     = 1'b0;
        wr_pulse = 1'b0;
        rd_pulse = 1'b0;
        fail_ev  = 1'b0;
        get_op   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    get_op = !req_put;
                    if (req_put) begin
                        if (!ofifo_full) begin
                            wr_pulse = 1'b1;
                            done     = 1'b1;
                        end else if (req_nonblk) begin
                            fail_ev = 1'b1;
                            done    = 1'b1;
                        end else begin
                            stall   = 1'b1;
                            state_d = ST_WAIT_PUT;
                        end
                    end else begin
                        if (ififo_exists) begin
                            rd_pulse = 1'b1;
                            done     = 1'b1;
                        end else if (req_nonblk) begin
                            fail_ev = 1'b1;
                            done    = 1'b1;
                        end else begin
                            stall   = 1'b1;
                            state_d = ST_WAIT_GET;
                        end
                    end
                end
            end
            ST_WAIT_PUT: begin
                if (!ofifo_full) begin
                    wr_pulse = 1'b1;
                    done     = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    stall = 1'b1;
                end
            end
            ST_WAIT_GET: begin
                get_op = 1'b1;
                if (ififo_exists) begin
                    rd_pulse = 1'b1;
                    done     = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    stall = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/fifo_link_result.sv
module fifo_link_result #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic              rd_pulse,
    input  logic              fail_ev,
    input  logic              get_op,
    input  logic              act_ctrl,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_ctrl,
    output logic [DATA_W-1:0] rdata,
    output logic              st_fail,
    output logic              st_ctrl_err
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata       <= '0;
            st_fail     <= 1'b0;
            st_ctrl_err <= 1'b0;
        end else if (rd_pulse) begin
            rdata       <= in_data;
            st_fail     <= 1'b0;
            st_ctrl_err <= (in_ctrl != act_ctrl);
        end else if (wr_pulse) begin
            st_fail <= 1'b0;
        end else if (fail_ev) begin
            st_fail <= 1'b1;
            if (get_op) begin
                rdata       <= '0;
                st_ctrl_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fifo_link_port.sv
module fifo_link_port #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_put,
    input  logic              req_nonblk,
    input  logic              req_ctrl,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              stall,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              st_fail,
    output logic              st_ctrl_err,
    output logic              ofifo_wr,
    output logic [DATA_W-1:0] ofifo_data,
    output logic              ofifo_ctrl,
    input  logic              ofifo_full,
    output logic              ififo_rd,
    input  logic [DATA_W-1:0] ififo_data,
    input  logic              ififo_ctrl,
    input  logic              ififo_exists
);
    logic fail_ev, get_op, act_ctrl;

    fifo_link_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_put(req_put), .req_nonblk(req_nonblk),
        .req_ctrl(req_ctrl), .req_wdata(req_wdata),
        .ofifo_full(ofifo_full), .ififo_exists(ififo_exists),
        .stall(stall), .done(done), .wr_pulse(ofifo_wr), .rd_pulse(ififo_rd),
        .fail_ev(fail_ev), .get_op(get_op), .act_ctrl(act_ctrl),
        .act_data(ofifo_data)
    );

    assign ofifo_ctrl = act_ctrl;

    fifo_link_result #(.DATA_W(DATA_W)) res_i (
        .clk(clk), .rst_n(rst_n),
        .wr_pulse(ofifo_wr), .rd_pulse(ififo_rd), .fail_ev(fail_ev),
        .get_op(get_op), .act_ctrl(act_ctrl),
        .in_data(ififo_data), .in_ctrl(ififo_ctrl),
        .rdata(rdata), .st_fail(st_fail), .st_ctrl_err(st_ctrl_err)
    );
endmodule

// File: rtl/fifo_link_port_chk.sv
module fifo_link_port_chk (
    input logic clk,
    input logic rst_n,
    input logic stall,
    input logic done,
    input logic ofifo_wr,
    input logic ofifo_full,
    input logic ififo_rd,
    input logic ififo_exists,
    input logic st_fail
);
    AST_WR_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        ofifo_wr |-> !ofifo_full); // R3
    AST_RD_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ififo_rd |-> ififo_exists); // R6
    AST_ONE_SIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ofifo_wr, ififo_rd}) <= 1); // R2
    AST_STALL_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !done); // R3
    AST_XFER_IS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ofifo_wr || ififo_rd) |-> done); // R5
    AST_NB_FAIL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ofifo_wr && !ififo_rd) |=> st_fail); // R4
    AST_OK_CLEARS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (ofifo_wr || ififo_rd) |=> !st_fail); // R4
endmodule

bind fifo_link_port fifo_link_port_chk chk_i (
    .clk(clk), .rst_n(rst_n), .stall(stall), .done(done),
    .ofifo_wr(ofifo_wr), .ofifo_full(ofifo_full),
    .ififo_rd(ififo_rd), .ififo_exists(ififo_exists), .st_fail(st_fail)
);

// File: tb/fifo_link_port_tb.sv
`timescale 1ns/1ps
module fifo_link_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_put = 0, req_nonblk = 0, req_ctrl = 0;
    logic [31:0] req_wdata = '0;
    logic        stall, done, st_fail, st_ctrl_err, ofifo_wr, ofifo_ctrl, ififo_rd;
    logic [31:0] rdata, ofifo_data;
    logic        ofifo_full = 0, ififo_ctrl = 0, ififo_exists = 0;
    logic [31:0] ififo_data = '0;
    int checks = 0, failures = 0;

    always #4 clk = ~clk;

    fifo_link_port dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_put(req_put),
        .req_nonblk(req_nonblk), .req_ctrl(req_ctrl), .req_wdata(req_wdata),
        .stall(stall), .done(done), .rdata(rdata), .st_fail(st_fail),
        .st_ctrl_err(st_ctrl_err), .ofifo_wr(ofifo_wr), .ofifo_data(ofifo_data),
        .ofifo_ctrl(ofifo_ctrl), .ofifo_full(ofifo_full), .ififo_rd(ififo_rd),
        .ififo_data(ififo_data), .ififo_ctrl(ififo_ctrl), .ififo_exists(ififo_exists)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive a request at the falling edge, then settle
    task automatic issue(input logic put, input logic nb, input logic c, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_put = put; req_nonblk = nb; req_ctrl = c; req_wdata = d;
        #1;
    endtask

    task automatic finish_req();
        @(posedge clk); #1;
        @(negedge clk);
        req_valid = 0; ofifo_full = 0; ififo_exists = 0;
    endtask

    task automatic t_reset();
        chk("R1 stall", stall, 0); chk("R1 wr", ofifo_wr, 0); chk("R1 rd", ififo_rd, 0);
        chk("R1 flags", {st_fail, st_ctrl_err}, 0); chk("R1 rdata", rdata, 0);
    endtask

    task automatic t_put_ok(input logic c, input logic [31:0] d);
        issue(1, 0, c, d);
        chk("R2 wr", ofifo_wr, 1); chk("R2 done", done, 1); chk("R2 stall", stall, 0);
        chk("R2 data", ofifo_data, d); chk("R2 ctrl", ofifo_ctrl, c);
        @(posedge clk); #1;
        chk("R4 fail cleared by put", st_fail, 0);
        @(negedge clk); req_valid = 0; #1;
        chk("R2 single pulse", ofifo_wr, 0);
    endtask

    task automatic t_put_nb_full();
        ofifo_full = 1;
        issue(1, 1, 0, 32'h1111_2222);
        chk("R4 no write", ofifo_wr, 0); chk("R4 done", done, 1);
        finish_req();
        chk("R4 fail set", st_fail, 1);
    endtask

    task automatic t_put_blocking();
        ofifo_full = 1;
        issue(1, 0, 1, 32'hCAFE_0001);
        chk("R3 stall", stall, 1); chk("R3 no write", ofifo_wr, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            req_wdata = 32'hBAD0_0000 + i; req_ctrl = 0; #1;
            chk("R3 still stalled", stall, 1); chk("R3 held", ofifo_wr, 0);
        end
        @(negedge clk); ofifo_full = 0; #1;
        chk("R3 write", ofifo_wr, 1); chk("R3 done", done, 1); chk("R3 unstall", stall, 0);
        chk("R9 latched data", ofifo_data, 32'hCAFE_0001); chk("R9 latched ctrl", ofifo_ctrl, 1);
        finish_req();
        chk("R4 blocking success clears", st_fail, 0);
    endtask

    task automatic t_get_ok(input logic want, input logic got, input logic [31:0] d);
        ififo_exists = 1; ififo_data = d; ififo_ctrl = got;
        issue(0, 0, want, 0);
        chk("R5 rd", ififo_rd, 1); chk("R5 done", done, 1); chk("R5 stall", stall, 0);
        finish_req();
        chk("R5 rdata", rdata, d); chk("R8 ctrl err", st_ctrl_err, want != got);
        chk("R4 get clears fail", st_fail, 0);
    endtask

    task automatic t_get_nb_empty();
        issue(0, 1, 0, 0);
        chk("R7 no rd", ififo_rd, 0); chk("R7 done", done, 1);
        finish_req();
        chk("R7 fail", st_fail, 1); chk("R7 rdata", rdata, 0); chk("R7 cerr", st_ctrl_err, 0);
    endtask

    task automatic t_get_blocking();
        issue(0, 0, 1, 0);
        chk("R6 stall", stall, 1); chk("R6 no rd", ififo_rd, 0);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); #1;
            chk("R6 still stalled", stall, 1); chk("R6 held", ififo_rd, 0);
        end
        @(negedge clk); ififo_exists = 1; ififo_data = 32'h0BAD_F00D; ififo_ctrl = 1; #1;
        chk("R6 rd", ififo_rd, 1); chk("R6 done", done, 1); chk("R6 unstall", stall, 0);
        finish_req();
        chk("R6 rdata", rdata, 32'h0BAD_F00D); chk("R8 match", st_ctrl_err, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;
        t_reset();
        t_put_ok(0, 32'hA5A5_5A5A);
        t_put_ok(1, 32'hFFFF_0000);
        t_put_nb_full();
        t_put_ok(0, 32'h0000_0001);
        t_put_blocking();
        t_get_ok(0, 0, 32'h1234_5678);
        t_get_ok(1, 0, 32'h8765_4321);
        t_put_ok(0, 32'h5555_AAAA);
        chk("R8 put keeps cerr", st_ctrl_err, 1);
        t_get_nb_empty();
        t_get_blocking();
        t_get_ok(0, 1, 32'hDEAD_BEEF);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule